// File: doc/BRIEF.md
# Sticky Interrupt Status Unit for a Quad SPI Controller

This block collects the interrupt sources of a quad SPI controller that moves data through transmit and receive FIFOs and a descriptor-driven DMA engine. Each cycle it derives level conditions from the two FIFO fill levels: empty, full, and a programmable threshold for each direction. It also takes single-cycle event pulses for descriptor done, packet complete and DMA error. Every source is latched into a sticky status register. A bit stays set until software clears it by writing a one to it.

A single interrupt line leaves the block. It is driven from a flop, and it is high only when some source is set in the status register and is also allowed by two independent masks: a status-enable register and a signal-enable gate. Because the status bits are sticky, an interrupt handler normally silences a source by dropping its enable bit. The status bit stays set until the handler chooses to clear it. A synchronous soft-reset input puts the block back into its post-reset configuration and records the empty state of both FIFOs as a new event.

Top module: `sqi_irq_hub`

## Requirements
- R1: Status, enable and signal-enable share one layout: bit 0 TX empty, bit 1 TX full, bit 2 TX threshold, bit 3 RX empty, bit 4 RX full, bit 5 RX threshold, bit 9 descriptor done, bit 10 packet complete, bit 11 DMA error. Bits 6 to 8 and bit 12 always read 0.
- R2: The TX threshold source is set in any cycle where the TX level is less than or equal to the TX threshold.
- R3: The RX threshold source is set in any cycle where the RX level is greater than or equal to the RX threshold.
- R4: An empty source is set when its FIFO level is 0. A full source is set when its level equals the FIFO depth (16 by default).
- R5: A source condition or event pulse present at a clock edge sets its status bit at that edge, whatever the enable and signal-enable values are.
- R6: A status bit that is set stays set until it is cleared by a write or a soft reset. Clearing its enable bit leaves it set.
- R7: Writing to status clears each bit written as 1 and leaves bits written as 0 unchanged. If the bit's condition is present in the same cycle, the bit stays set.
- R8: `irq` is high in the cycle after an edge at which at least one bit is set in status, enable and signal-enable together, and low otherwise.
- R9: A soft-reset pulse leaves status at 0x009 (only TX empty and RX empty), clears enable and signal-enable, and returns both thresholds to 1. Writes and events in that cycle are ignored.
- R10: The threshold register holds the TX threshold in bits 12:8 and the RX threshold in bits 4:0, and its reset value is 0x0101. Enable and signal-enable keep only the implemented bits of R1. Hardware reset clears status, enable and signal-enable.
- R11: `reg_sel` chooses the register: 0 status, 1 enable, 2 signal-enable, 3 threshold. `reg_rdata` shows the selected register as it stands after the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft-reset pulse |
| tx_level | input | 5 | TX FIFO fill level, 0 to depth |
| rx_level | input | 5 | RX FIFO fill level, 0 to depth |
| desc_done | input | 1 | Descriptor-done event pulse |
| pkt_done | input | 1 | Packet-complete event pulse |
| dma_err | input | 1 | DMA error event pulse |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 13 | Write data |
| reg_rdata | output | 13 | Read data of the selected register |
| irq | output | 1 | Registered interrupt line |

## Verification
A fault in a status flop shows on `reg_rdata` in the cycle after the edge that corrupts it. Because the bit is sticky, it then stays wrong until the next clear, so every later status read also exposes it. A fault in the gating or in the enable registers shows on `irq` exactly one edge after the gating terms change. The bench therefore compares `irq` on every cycle, not only after directed writes. Threshold comparison errors are exposed by driving levels one below, at and one beyond each programmed threshold, with the status read in the cycle after each edge.

// File: rtl/sqi_irq_pkg.sv
package sqi_irq_pkg;

  // Number of status bit positions and register data width
  localparam int NSRC   = 12;
  localparam int DATA_W = 13;
  localparam int THR_W  = 5;

  // Source bit positions (the layout is shared by status and both masks)
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_THR   = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_THR   = 5;
  localparam int B_DESC     = 9;
  localparam int B_PKT      = 10;
  localparam int B_DMAERR   = 11;

  localparam logic [NSRC-1:0] SRC_MASK  = 12'hE3F;
  localparam logic [NSRC-1:0] SOFT_SEED = 12'h009;
  localparam logic [THR_W-1:0] THR_DEFAULT = 5'd1;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_SIGEN  = 2'd2,
    SEL_THRESH = 2'd3
  } reg_sel_e;

  // Transmit side wants service while it has drained to the mark
  function automatic logic tx_mark_met(int unsigned lvl, int unsigned mark);
    return lvl <= mark;
  endfunction

  // Receive side wants service once it has filled to the mark
  function automatic logic rx_mark_met(int unsigned lvl, int unsigned mark);
    return lvl >= mark;
  endfunction

  function automatic logic [DATA_W-1:0] pack_thresh(logic [THR_W-1:0] txm,
                                                    logic [THR_W-1:0] rxm);
    return {txm, 3'b000, rxm};
  endfunction

endpackage

// File: rtl/sqi_irq_cond.sv
module sqi_irq_cond
  import sqi_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_mark,
  input  logic [THR_W-1:0] rx_mark,
  input  logic             desc_done,
  input  logic             pkt_done,
  input  logic             dma_err,
  output logic [NSRC-1:0]  set_vec
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // Named level events, visible to assertions and waveforms
  logic tx_empty_w, tx_full_w, tx_mark_w;
  logic rx_empty_w, rx_full_w, rx_mark_w;

  assign tx_empty_w = (tx_level == '0);
  assign tx_full_w  = (tx_level == FULL_LVL);
  assign tx_mark_w  = tx_mark_met(32'(tx_level), 32'(tx_mark));
  assign rx_empty_w = (rx_level == '0);
  assign rx_full_w  = (rx_level == FULL_LVL);
  assign rx_mark_w  = rx_mark_met(32'(rx_level), 32'(rx_mark));

  always_comb begin
    set_vec             = '0;
    set_vec[B_TX_EMPTY] = tx_empty_w;
    set_vec[B_TX_FULL]  = tx_full_w;
    set_vec[B_TX_THR]   = tx_mark_w;
    set_vec[B_RX_EMPTY] = rx_empty_w;
    set_vec[B_RX_FULL]  = rx_full_w;
    set_vec[B_RX_THR]   = rx_mark_w;
    set_vec[B_DESC]     = desc_done;
    set_vec[B_PKT]      = pkt_done;
    set_vec[B_DMAERR]   = dma_err;
  end

  // A FIFO cannot be empty and full at once when depth is non-zero
  always_comb begin
    if (DEPTH > 0) begin
      a_empty_full_excl_r4: assert (!(tx_empty_w && tx_full_w) && !(rx_empty_w && rx_full_w));
    end
  end

endmodule

// File: rtl/sqi_irq_status.sv
module sqi_irq_status
  import sqi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_i,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status_o
);

  logic [NSRC-1:0] st_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q[i] <= 1'b0;
      else if (soft_i) st_q[i] <= SOFT_SEED[i];
      else             st_q[i] <= (st_q[i] & ~clr_vec[i]) | set_vec[i];
    end

    if (SRC_MASK[i]) begin : g_impl
      p_event_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[i] && !soft_i) |=> status_o[i]);
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[i] && !clr_vec[i] && !soft_i) |=> status_o[i]);
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[i] && clr_vec[i] && !set_vec[i] && !soft_i) |=> !status_o[i]);
    end else begin : g_hole
      p_hole_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[i]);
    end
  end

  assign status_o = st_q & SRC_MASK;

  p_soft_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_i |=> (status_o == SOFT_SEED));

endmodule

// File: rtl/sqi_irq_regs.sv
module sqi_irq_regs
  import sqi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_i,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   sig_o,
  output logic [THR_W-1:0]  tx_mark_o,
  output logic [THR_W-1:0]  rx_mark_o,
  output logic [NSRC-1:0]   clr_vec,
  output logic [DATA_W-1:0] reg_rdata
);

  reg_sel_e sel;
  logic wr_status, wr_enable, wr_sigen, wr_thresh;

  assign sel       = reg_sel_e'(reg_sel);
  assign wr_status = reg_wr && (sel == SEL_STATUS);
  assign wr_enable = reg_wr && (sel == SEL_ENABLE);
  assign wr_sigen  = reg_wr && (sel == SEL_SIGEN);
  assign wr_thresh = reg_wr && (sel == SEL_THRESH);

  assign clr_vec = wr_status ? reg_wdata[NSRC-1:0] : '0;

  logic [NSRC-1:0]  en_q, sig_q;
  logic [THR_W-1:0] txm_q, rxm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sig_q <= '0;
      txm_q <= THR_DEFAULT;
      rxm_q <= THR_DEFAULT;
    end else if (soft_i) begin
      en_q  <= '0;
      sig_q <= '0;
      txm_q <= THR_DEFAULT;
      rxm_q <= THR_DEFAULT;
    end else begin
      if (wr_enable) en_q  <= reg_wdata[NSRC-1:0] & SRC_MASK;
      if (wr_sigen)  sig_q <= reg_wdata[NSRC-1:0] & SRC_MASK;
      if (wr_thresh) begin
        txm_q <= reg_wdata[12:8];
        rxm_q <= reg_wdata[THR_W-1:0];
      end
    end
  end

  assign en_o      = en_q;
  assign sig_o     = sig_q;
  assign tx_mark_o = txm_q;
  assign rx_mark_o = rxm_q;

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = {1'b0, status_i};
      SEL_ENABLE: reg_rdata = {1'b0, en_q};
      SEL_SIGEN:  reg_rdata = {1'b0, sig_q};
      SEL_THRESH: reg_rdata = pack_thresh(txm_q, rxm_q);
      default:    reg_rdata = '0;
    endcase
  end

  p_soft_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_i |=> (en_o == '0 && sig_o == '0 &&
                tx_mark_o == THR_DEFAULT && rx_mark_o == THR_DEFAULT));
  p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enable && !soft_i) |=> $stable(en_o));
  p_sigen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sigen && !soft_i) |=> $stable(sig_o));

endmodule

// File: rtl/sqi_irq_hub.sv
module sqi_irq_hub
  import sqi_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              desc_done,
  input  logic              pkt_done,
  input  logic              dma_err,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic [NSRC-1:0]  set_w, clr_w, status_w, en_w, sig_w;
  logic [THR_W-1:0] txm_w, rxm_w;
  logic             gate_w;
  logic             irq_q;

  sqi_irq_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_mark  (txm_w),
    .rx_mark  (rxm_w),
    .desc_done(desc_done),
    .pkt_done (pkt_done),
    .dma_err  (dma_err),
    .set_vec  (set_w)
  );

  sqi_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_i  (soft_rst),
    .set_vec (set_w),
    .clr_vec (clr_w),
    .status_o(status_w)
  );

  sqi_irq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_i   (soft_rst),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .status_i (status_w),
    .en_o     (en_w),
    .sig_o    (sig_w),
    .tx_mark_o(txm_w),
    .rx_mark_o(rxm_w),
    .clr_vec  (clr_w),
    .reg_rdata(reg_rdata)
  );

  // Both masks must pass a pending source before the line can rise
  assign gate_w = |(status_w & en_w & sig_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gate_w;
  end

  assign irq = irq_q;

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_w & en_w & sig_w)) |=> irq);
  p_irq_needs_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(|status_w) && $past(|en_w) && $past(|sig_w)));

endmodule

// File: tb/sim_sqi_irq_hub.sv
module sim_sqi_irq_hub;

  localparam int DEPTH = 16;
  localparam logic [11:0] IMPL = 12'hE3F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [4:0]  tx_level = 5'd8;
  logic [4:0]  rx_level = 5'd4;
  logic        desc_done = 1'b0, pkt_done = 1'b0, dma_err = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [12:0] reg_wdata = '0;
  logic [12:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  // Reference state, computed from the requirements
  logic [11:0] m_st, m_en, m_sig;
  logic [4:0]  m_txt, m_rxt;

  always #5ns clk = ~clk;

  sqi_irq_hub #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .desc_done(desc_done), .pkt_done(pkt_done), .dma_err(dma_err),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [12:0] got, logic [12:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] src_now(int txl, int rxl, bit bd, bit pk, bit er,
                                          int txt, int rxt);
    logic [11:0] s = '0;
    s[0]  = (txl == 0);
    s[1]  = (txl == DEPTH);
    s[2]  = (txl <= txt);
    s[3]  = (rxl == 0);
    s[4]  = (rxl == DEPTH);
    s[5]  = (rxl >= rxt);
    s[9]  = bd;
    s[10] = pk;
    s[11] = er;
    return s;
  endfunction

  function automatic logic [12:0] view(logic [1:0] sel);
    case (sel)
      2'd0:    return {1'b0, m_st};
      2'd1:    return {1'b0, m_en};
      2'd2:    return {1'b0, m_sig};
      default: return {m_txt, 3'b000, m_rxt};
    endcase
  endfunction

  // Drive one cycle at the falling edge, then check after the next rise
  task automatic step(bit wr, logic [1:0] sel, logic [12:0] wd, int txl, int rxl,
                      bit bd, bit pk, bit er, bit sr, string req);
    logic [11:0] s, clr;
    bit gate;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    tx_level = 5'(txl); rx_level = 5'(rxl);
    desc_done = bd; pkt_done = pk; dma_err = er; soft_rst = sr;
    s = src_now(txl, rxl, bd, pk, er, int'(m_txt), int'(m_rxt));
    gate = |(m_st & m_en & m_sig);
    @(posedge clk);
    if (sr) begin
      m_st = 12'h009; m_en = '0; m_sig = '0; m_txt = 5'd1; m_rxt = 5'd1;
    end else begin
      clr = (wr && sel == 2'd0) ? wd[11:0] : 12'h000;
      m_st = (m_st & ~clr) | s;
      if (wr && sel == 2'd1) m_en = wd[11:0] & IMPL;
      if (wr && sel == 2'd2) m_sig = wd[11:0] & IMPL;
      if (wr && sel == 2'd3) begin m_txt = wd[12:8]; m_rxt = wd[4:0]; end
    end
    @(negedge clk);
    chk("R8 irq", {12'b0, irq}, {12'b0, gate});
    chk(req, reg_rdata, view(sel));
  endtask

  // Quiet levels: thresholds 3 (TX) and 12 (RX) leave every source idle
  task automatic quiet_clear(string req);
    step(1, 2'd0, 13'hFFF, 8, 4, 0, 0, 0, 0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'h5A17);
    m_st = '0; m_en = '0; m_sig = '0; m_txt = 5'd1; m_rxt = 5'd1;

    // Reset state (R10)
    repeat (3) @(negedge clk);
    reg_sel = 2'd0; #1ns;
    chk("R10 reset status", reg_rdata, 13'h0000);
    reg_sel = 2'd3; #1ns;
    chk("R10 reset threshold", reg_rdata, 13'h0101);
    chk("R8 reset irq", {12'b0, irq}, 13'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Threshold layout (R10), then clear
    step(1, 2'd3, {5'd3, 3'b111, 5'd12}, 8, 4, 0, 0, 0, 0, "R10 thresh layout");
    quiet_clear("R7 clear all");

    // TX threshold boundary (R2)
    step(0, 2'd0, '0, 4, 4, 0, 0, 0, 0, "R2 tx above mark");
    step(0, 2'd0, '0, 3, 4, 0, 0, 0, 0, "R2 tx at mark");
    quiet_clear("R7");
    // RX threshold boundary (R3)
    step(0, 2'd0, '0, 8, 11, 0, 0, 0, 0, "R3 rx below mark");
    step(0, 2'd0, '0, 8, 12, 0, 0, 0, 0, "R3 rx at mark");
    quiet_clear("R7");
    // Empty and full (R4)
    step(0, 2'd0, '0, 16, 4, 0, 0, 0, 0, "R4 tx full");
    step(0, 2'd0, '0, 8, 16, 0, 0, 0, 0, "R4 rx full");
    quiet_clear("R7");
    step(0, 2'd0, '0, 0, 0, 0, 0, 0, 0, "R4 both empty");
    quiet_clear("R7");
    // Event pulses latched with masks off, layout of R1
    step(0, 2'd0, '0, 8, 4, 1, 0, 0, 0, "R5 desc done");
    step(0, 2'd0, '0, 8, 4, 0, 1, 0, 0, "R5 packet done");
    step(0, 2'd0, '0, 8, 4, 0, 0, 1, 0, "R1 dma error bit 11");
    // Masks keep only implemented bits
    step(1, 2'd1, 13'h1FFF, 8, 4, 0, 0, 0, 0, "R10 enable mask");
    step(0, 2'd0, '0, 8, 4, 0, 0, 0, 0, "R8 enable alone no irq");
    step(1, 2'd2, 13'h0200, 8, 4, 0, 0, 0, 0, "R10 sigen write");
    step(0, 2'd0, '0, 8, 4, 0, 0, 0, 0, "R8 irq rises");
    // Drop enable: irq falls, status kept (R6)
    step(1, 2'd1, 13'h0000, 8, 4, 0, 0, 0, 0, "R6 disable");
    step(0, 2'd0, '0, 8, 4, 0, 0, 0, 0, "R6 status kept");
    // Clear while condition present (R7)
    step(0, 2'd0, '0, 0, 4, 0, 0, 0, 0, "R4 tx empty");
    step(1, 2'd0, 13'h0001, 0, 4, 0, 0, 0, 0, "R7 clear with condition held");
    step(1, 2'd0, 13'h0001, 8, 4, 0, 0, 0, 0, "R7 clear once condition gone");
    // Soft reset ignores a same-cycle write and event (R9)
    step(1, 2'd1, 13'h0FFF, 8, 4, 0, 1, 0, 0, "R10 enable all");
    step(1, 2'd1, 13'h0FFF, 8, 4, 1, 0, 0, 1, "R9 soft reset enable");
    step(0, 2'd0, '0, 8, 4, 0, 0, 0, 0, "R9 soft reset status");
    step(0, 2'd3, '0, 8, 4, 0, 0, 0, 0, "R9 soft reset thresholds");

    // Random traffic with register map checks (R11)
    for (int k = 0; k < 600; k++) begin
      bit wr, bd, pk, er, sr;
      logic [1:0] sel;
      wr  = ($urandom_range(0, 2) == 0);
      sel = 2'($urandom_range(0, 3));
      bd  = ($urandom_range(0, 3) == 0);
      pk  = ($urandom_range(0, 5) == 0);
      er  = ($urandom_range(0, 7) == 0);
      sr  = ($urandom_range(0, 49) == 0);
      step(wr, sel, 13'($urandom), $urandom_range(0, DEPTH), $urandom_range(0, DEPTH),
           bd, pk, er, sr, "R11 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule